// File: doc/BRIEF.md
# Three-wire serial EEPROM word-store model

This block behaves like a small serial EEPROM with a chip-select line, a serial clock, a serial data input and a serial data output. The words are 16 bits wide and the address is either 6 or 8 bits. A host raises chip select and shifts in a start bit, a two-bit operation code and an address, each bit taken on a rising edge of the serial clock. Write-type operations then take 16 data bits. A read returns its word on the data output.

All lines are sampled by the system clock `clk`, which must run well above the serial clock. The model detects serial-clock rising edges on its own. The storage is a register array, and a reset leaves every word erased.

Every programming operation is gated by a write-enable latch. After each programming operation the model stays busy for a short, parameterised number of system clocks. An instruction whose start bit arrives in that window is discarded.

Top module: `uwire_eeprom_model`

## Requirements
- R1: Zeros clocked in while chip select is high and no instruction is open are ignored. The first 1 is the start bit. It is followed by a 2-bit code, MSB first: 10 read, 01 write, 11 erase, 00 extended. Then come ADDR_W address bits, MSB first.
- R2: After reset, and in the system clock cycle after chip select is seen low, the data output is 0.
- R3: For code 00, the two address MSBs select the extended command: 11 enables programming, 00 disables it, 10 erases all words, 01 writes all words. The remaining address bits are ignored. Programming is disabled after reset.
- R4: The data output changes only in the system cycle after a serial-clock rising edge is seen while chip select is high, or when chip select drops.
- R5: A read drives a 0 after the last address bit. The next 16 rising edges then present the word, bit 15 first.
- R6: A write takes 16 data bits, bit 15 first, and stores them at the addressed word.
- R7: An erase sets the addressed word to 16'hFFFF and leaves the other words unchanged.
- R8: Erase-all sets every word to 16'hFFFF. Write-all stores its 16 data bits into every word.
- R9: A programming operation makes the block busy for BUSY_CYC system clocks. A start bit that arrives while busy voids the whole instruction, up to the next chip-select low.
- R10: Dropping chip select before the last data bit of a write leaves the memory unchanged.
- R11: Write, erase, erase-all and write-all leave the memory unchanged while programming is disabled.
- R12: Reset leaves every word at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and state |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data into the model |
| do_o | output | 1 | Serial data out of the model |

## Verification
The bench writes a distinct arithmetic pattern into every word and reads it all back. A design with a bit-order or address-shift error would return swapped or misplaced words, and one without the leading zero would return every word shifted by one bit. The bench issues every programming command while the latch is clear; a design that skipped the latch check would corrupt words it should protect. It also truncates a write, starts an instruction during the busy window, and holds the serial clock low mid-read. These catch a design that commits partial data, accepts a command while still programming, or advances output on the system clock instead of serial-clock edges.

// File: rtl/uwire_eeprom_model.sv
module uwire_eeprom_model #(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int HDR_W = 2 + ADDR_W;
  localparam int BW    = $clog2(BUSY_CYC + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_HDR = 3'd1, S_READ = 3'd2,
                         S_DATA = 3'd3, S_DONE = 3'd4;

  logic [2:0]        st;
  logic [4:0]        cnt;
  logic [HDR_W-1:0]  hdr;
  logic [15:0]       sr;
  logic [15:0]       mem [WORDS];
  logic              pe, sk_q;
  logic [BW-1:0]     busy;

  wire              sk_rise  = cs & sk & ~sk_q;
  wire [HDR_W-1:0]  hdr_nx   = {hdr[HDR_W-2:0], di};
  wire [1:0]        op_nx    = hdr_nx[HDR_W-1 -: 2];
  wire [ADDR_W-1:0] adr_nx   = hdr_nx[ADDR_W-1:0];
  wire [1:0]        ext_nx   = adr_nx[ADDR_W-1 -: 2];
  wire [1:0]        op_q     = hdr[HDR_W-1 -: 2];
  wire [ADDR_W-1:0] adr_q    = hdr[ADDR_W-1:0];
  wire [15:0]       sr_nx    = {sr[14:0], di};
  wire              hdr_last = (st == S_HDR) && sk_rise && (cnt == 5'(HDR_W - 1));
  wire              dat_last = (st == S_DATA) && sk_rise && (cnt == 5'd15);
  wire              wr_one   = pe && dat_last && (op_q == 2'b01);
  wire              wr_all   = pe && dat_last && (op_q == 2'b00);
  wire              er_one   = pe && hdr_last && (op_nx == 2'b11);
  wire              er_all   = pe && hdr_last && (op_nx == 2'b00) && (ext_nx == 2'b10);
  wire              prog     = wr_one | wr_all | er_one | er_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; hdr <= '0; sr <= '0;
      pe <= 1'b0; sk_q <= 1'b0; busy <= '0; do_o <= 1'b0;
    end else begin
      sk_q <= sk;
      if (prog) busy <= BW'(BUSY_CYC);
      else if (busy != '0) busy <= busy - 1'b1;
      if (!cs) begin
        st <= S_IDLE; cnt <= '0; do_o <= 1'b0;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di) begin
            st  <= (busy != '0) ? S_DONE : S_HDR;
            cnt <= '0;
          end
          S_HDR: begin
            hdr <= hdr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == 5'(HDR_W - 1)) begin
              cnt <= '0;
              case (op_nx)
                2'b10: begin st <= S_READ; sr <= mem[adr_nx]; do_o <= 1'b0; end
                2'b01: st <= S_DATA;
                2'b11: st <= S_DONE;
                default: begin
                  st <= (ext_nx == 2'b01) ? S_DATA : S_DONE;
                  if (ext_nx == 2'b11) pe <= 1'b1;
                  if (ext_nx == 2'b00) pe <= 1'b0;
                end
              endcase
            end
          end
          S_READ: begin
            cnt  <= cnt + 1'b1;
            do_o <= sr[15];
            sr   <= {sr[14:0], 1'b0};
            if (cnt == 5'd16) begin st <= S_DONE; do_o <= 1'b0; end
          end
          S_DATA: begin
            sr  <= sr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == 5'd15) st <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || er_all) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (wr_all) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= sr_nx;
    end else if (wr_one) begin
      mem[adr_q] <= sr_nx;
    end else if (er_one) begin
      mem[adr_nx] <= 16'hFFFF;
    end
  end
endmodule

module uwire_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       sk,
  input logic       do_o,
  input logic [2:0] st,
  input logic       pe,
  input logic       busy_nz
);
  localparam logic [2:0] C_IDLE = 3'd0, C_HDR = 3'd1, C_READ = 3'd2;

  AST_DO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_o); // R2
  AST_DO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $past(cs) && !$stable(do_o)) |-> ($past(sk) && !$past(sk, 2))); // R4
  AST_READ_LEAD0: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_READ && $past(st) != C_READ) |-> !do_o); // R5
  AST_PE_FROM_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pe) |-> ($past(st) == C_HDR && $past(cs))); // R3
  AST_BUSY_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_nz) && $past(st) == C_IDLE) |-> st != C_HDR); // R9
endmodule

bind uwire_eeprom_model uwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .do_o(do_o),
  .st(st), .pe(pe), .busy_nz(busy != '0)
);

// File: tb/uwire_eeprom_model_tb_top.sv
module uwire_eeprom_model_tb_top;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  wire  do_o;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uwire_eeprom_model #(.ADDR_W(AW), .BUSY_CYC(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o));

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 1031) ^ 16'h5A3C);
  endfunction

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bitc(input logic b, output logic o);
    sk = 1'b0; di = b; repeat (2) @(negedge clk);
    sk = 1'b1; repeat (2) @(negedge clk);
    o = do_o;
  endtask

  task automatic send16(input logic [15:0] v);
    logic o;
    for (int i = 15; i >= 0; i--) bitc(v[i], o);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [AW-1:0] a, output logic lead);
    logic o;
    cs = 1'b1; @(negedge clk);
    bitc(1'b1, o); bitc(op[1], o); bitc(op[0], o);
    for (int i = AW - 1; i >= 0; i--) bitc(a[i], o);
    lead = o;
  endtask

  task automatic fin(input int w);
    sk = 1'b0; di = 1'b0; @(negedge clk);
    cs = 1'b0; repeat (w) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d, output logic lead);
    logic o;
    hdr(2'b10, a, lead);
    for (int i = 15; i >= 0; i--) begin bitc(1'b0, o); d[i] = o; end
    fin(3);
  endtask

  task automatic rd_chk(input string r, input logic [AW-1:0] a, input logic [15:0] exp);
    logic [15:0] d; logic l;
    rd(a, d, l);
    chk(r, d, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input int w);
    logic l;
    hdr(2'b01, a, l); send16(d); fin(w);
  endtask

  task automatic ext(input logic [1:0] code);
    logic l;
    hdr(2'b00, {code, {(AW-2){1'b0}}}, l); fin(24);
  endtask

  task automatic er(input logic [AW-1:0] a);
    logic l;
    hdr(2'b11, a, l); fin(24);
  endtask

  task automatic wral(input logic [15:0] d);
    logic l;
    hdr(2'b00, {2'b01, {(AW-2){1'b0}}}, l); send16(d); fin(24);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] d; logic l, o;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    chk("R2 reset do", {15'd0, do_o}, 16'd0);
    rd_chk("R12 reset word 0", 0, 16'hFFFF);
    rd_chk("R12 reset word top", AW'(NW - 1), 16'hFFFF);

    wr(5, 16'h1234, 24);
    rd_chk("R11 R3 write before enable", 5, 16'hFFFF);

    ext(2'b11);
    for (int a = 0; a < NW; a++) wr(AW'(a), pat(a), 24);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), d, l);
      chk("R5 lead zero", {15'd0, l}, 16'd0);
      chk("R6 R5 sweep", d, pat(a));
    end

    cs = 1'b1; @(negedge clk);
    bitc(1'b0, o); bitc(1'b0, o);
    rd(3, d, l);
    chk("R1 zeros before start", d, pat(3));

    hdr(2'b10, 3, l);
    sk = 1'b0; repeat (6) @(negedge clk);
    chk("R4 no edge no change", {15'd0, do_o}, 16'd0);
    bitc(1'b0, o);
    chk("R4 edge gives bit15", {15'd0, o}, {15'd0, pat(3)[15]});
    fin(3);

    ext(2'b00);
    wr(3, 16'h0BAD, 24);
    er(4);
    wral(16'h7777);
    hdr(2'b00, {2'b10, {(AW-2){1'b0}}}, l); fin(24);
    rd_chk("R11 locked write", 3, pat(3));
    rd_chk("R11 locked erase", 4, pat(4));
    rd_chk("R11 locked wral/eral", 10, pat(10));

    ext(2'b11);
    er(7);
    rd_chk("R7 erased word", 7, 16'hFFFF);
    rd_chk("R7 neighbour kept", 8, pat(8));

    hdr(2'b01, 9, l);
    for (int i = 0; i < 8; i++) bitc(1'b0, o);
    fin(24);
    rd_chk("R10 aborted write", 9, pat(9));

    wr(2, 16'h1111, 1);
    wr(3, 16'h2222, 24);
    rd_chk("R9 first write", 2, 16'h1111);
    rd_chk("R9 busy write void", 3, pat(3));

    wral(16'hA5C3);
    for (int a = 0; a < NW; a += 5) rd_chk("R8 write all", AW'(a), 16'hA5C3);
    hdr(2'b00, {2'b10, 4'b0101}, l); fin(24);
    for (int a = 0; a < NW; a += 7) rd_chk("R8 R3 erase all", AW'(a), 16'hFFFF);

    wr(1, 16'h4321, 24);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R2 do after reset", {15'd0, do_o}, 16'd0);
    wr(1, 16'h5555, 24);
    rd_chk("R3 R12 disabled after reset", 1, 16'hFFFF);

    summary();
  end
endmodule